// File: doc/BRIEF.md
# Adaptive Wait-Time Successive Approximator

This block learns the shortest wait that a peripheral operation of fairly repeatable length really needs. Software or a sequencer configures a worst-case delay in clock ticks. The block then times each attempt of the operation. A start pulse begins a countdown of the current trial delay, and a one-cycle done pulse marks its end. The agent that checks the result, for example by reading back the data, then returns a pass or fail verdict. The block uses that verdict to pick the next trial delay.

The search is a binary search with very little arithmetic. It uses one shift, one subtract and one add. A pass halves the trial delay and records it as the last known good delay. A fail moves the trial back up by half the gap to that good delay. When the step would be smaller than one tick, the block raises a converged flag. From then on it keeps timing with the last good delay and never changes it again until reset.

Top module: `wait_tuner`

## Requirements
- R1: While the synchronous active-high reset is held, the trial delay and the last good delay both load the worst-case input. A worst-case value of 0 is clamped to 1. Converged and done read 0.
- R2: A start accepted while idle makes done rise exactly trial-delay cycles after the clock edge that samples start. Done is high for a single cycle.
- R3: A start that arrives while a countdown runs, or while a verdict is still awaited, is ignored. It neither restarts the countdown nor adds a second done.
- R4: On a pass verdict the last good delay takes the current trial value. The trial becomes floor(trial/2), clamped to a minimum of 1.
- R5: On a fail verdict the trial grows by floor((last good - trial)/2). It never exceeds the last good delay.
- R6: When the step is zero, converged is set. This happens on a pass at trial 1, or on a fail with the trial within one tick of the last good delay. On a fail the trial then takes the last good delay.
- R7: Once converged is set, it stays set and verdicts no longer change the trial delay. Later starts still time the frozen delay.
- R8: A verdict offered while no verdict is awaited has no effect on the trial delay. A verdict is awaited from the cycle done rises until a verdict is taken.
- R9: When an attempt passes exactly when its delay is at least some threshold no larger than the worst case, the frozen delay equals that threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| worst_delay | input | DELAY_W | Configured worst-case delay in ticks |
| start | input | 1 | Begin an attempt (one-cycle pulse) |
| verdict_valid | input | 1 | Verdict for the last attempt is present |
| verdict_pass | input | 1 | 1 = attempt passed, 0 = failed |
| done | output | 1 | One-cycle pulse when the wait expires |
| trial_delay | output | DELAY_W | Current trial delay in ticks |
| converged | output | 1 | Search has settled; delay frozen |

## Verification
The assertions take two things for granted about the inputs. The worst-case input must stay steady outside reset, so that the trial value loaded under reset is not compared with a moving input. A verdict is counted only when the block awaits one. The stimulus meets the first by changing the worst case only while reset is held. It meets the second by mostly returning verdicts after done. It also deliberately offers stray verdicts and starts mid-countdown, and checks that they are ignored. Pass and fail come from a random hidden threshold no larger than the worst case, so the outcome is monotonic in the delay, as the search assumes.

// File: rtl/wtn_pkg.sv
package wtn_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_AWAIT = 2'd2
  } wtn_state_e;
endpackage

// File: rtl/wtn_countdown.sv
module wtn_countdown #(
  parameter int DELAY_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               arm,
  input  logic [DELAY_W-1:0] len,
  output logic               expiring,
  output logic               running,
  output logic               done_q
);
  logic [DELAY_W-1:0] remain_q;

  // Last tick of a running countdown.
  assign expiring = running && (remain_q == DELAY_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
      running  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (arm && !running) begin
        remain_q <= len;
        running  <= 1'b1;
      end else if (running) begin
        if (expiring) begin
          running <= 1'b0;
          done_q  <= 1'b1;
        end else begin
          remain_q <= remain_q - DELAY_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/wtn_step.sv
module wtn_step #(
  parameter int DELAY_W = 16
) (
  input  logic [DELAY_W-1:0] trial,
  input  logic [DELAY_W-1:0] good,
  input  logic               pass,
  output logic [DELAY_W-1:0] next_trial,
  output logic [DELAY_W-1:0] next_good,
  output logic               settle
);
  logic [DELAY_W-1:0] halved;
  logic [DELAY_W-1:0] gap_half;

  always_comb begin
    halved   = trial >> 1;
    gap_half = (good - trial) >> 1;
    if (pass) begin
      next_good = trial;
      if (halved == '0) begin
        next_trial = DELAY_W'(1);
        settle     = (trial == DELAY_W'(1));
      end else begin
        next_trial = halved;
        settle     = 1'b0;
      end
    end else begin
      next_good = good;
      if (gap_half == '0) begin
        next_trial = good;
        settle     = 1'b1;
      end else begin
        next_trial = trial + gap_half;
        settle     = 1'b0;
      end
    end
  end
endmodule

// File: rtl/wtn_search.sv
module wtn_search #(
  parameter int DELAY_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DELAY_W-1:0] worst,
  input  logic               update,
  input  logic               pass,
  output logic [DELAY_W-1:0] trial_q,
  output logic [DELAY_W-1:0] good_q,
  output logic               settled_q
);
  logic [DELAY_W-1:0] nxt_trial;
  logic [DELAY_W-1:0] nxt_good;
  logic               nxt_settle;
  logic [DELAY_W-1:0] worst_safe;

  assign worst_safe = (worst == '0) ? DELAY_W'(1) : worst;

  wtn_step #(.DELAY_W(DELAY_W)) u_step (
    .trial      (trial_q),
    .good       (good_q),
    .pass       (pass),
    .next_trial (nxt_trial),
    .next_good  (nxt_good),
    .settle     (nxt_settle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trial_q   <= worst_safe;
      good_q    <= worst_safe;
      settled_q <= 1'b0;
    end else if (update && !settled_q) begin
      trial_q   <= nxt_trial;
      good_q    <= nxt_good;
      settled_q <= nxt_settle;
    end
  end
endmodule

// File: rtl/wait_tuner.sv
module wait_tuner
  import wtn_pkg::*;
#(
  parameter int DELAY_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DELAY_W-1:0] worst_delay,
  input  logic               start,
  input  logic               verdict_valid,
  input  logic               verdict_pass,
  output logic               done,
  output logic [DELAY_W-1:0] trial_delay,
  output logic               converged
);
  wtn_state_e         state_q;
  logic               arm;
  logic               expiring;
  logic               running;
  logic               take_verdict;
  logic [DELAY_W-1:0] last_pass_w;

  assign arm          = (state_q == ST_IDLE) && start;
  assign take_verdict = (state_q == ST_AWAIT) && verdict_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (arm)          state_q <= ST_COUNT;
        ST_COUNT: if (expiring)     state_q <= ST_AWAIT;
        ST_AWAIT: if (take_verdict) state_q <= ST_IDLE;
        default:                    state_q <= ST_IDLE;
      endcase
    end
  end

  wtn_countdown #(.DELAY_W(DELAY_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .arm      (arm),
    .len      (trial_delay),
    .expiring (expiring),
    .running  (running),
    .done_q   (done)
  );

  wtn_search #(.DELAY_W(DELAY_W)) u_search (
    .clk       (clk),
    .rst       (rst),
    .worst     (worst_delay),
    .update    (take_verdict),
    .pass      (verdict_pass),
    .trial_q   (trial_delay),
    .good_q    (last_pass_w),
    .settled_q (converged)
  );
endmodule

// File: rtl/wtn_checks.sv
module wtn_checks #(
  parameter int DELAY_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               verdict_valid,
  input logic               done,
  input logic [DELAY_W-1:0] trial_delay,
  input logic [DELAY_W-1:0] last_pass,
  input logic               converged
);
  // R2: done lasts one cycle
  a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: trial never reaches zero
  a_r4_trial_nonzero: assert property (@(posedge clk) disable iff (rst)
    trial_delay != '0);

  // R5: trial never above last good delay
  a_r5_below_good: assert property (@(posedge clk) disable iff (rst)
    trial_delay <= last_pass);

  // R7: converged sticks and freezes the delay
  a_r7_frozen: assert property (@(posedge clk) disable iff (rst)
    converged |=> (converged && $stable(trial_delay)));

  // R8: no verdict, no change of trial
  a_r8_no_verdict_stable: assert property (@(posedge clk) disable iff (rst)
    !verdict_valid |=> $stable(trial_delay));
endmodule

bind wait_tuner wtn_checks #(.DELAY_W(DELAY_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .verdict_valid (verdict_valid),
  .done          (done),
  .trial_delay   (trial_delay),
  .last_pass     (last_pass_w),
  .converged     (converged)
);

// File: tb/wait_tuner_test.sv
module wait_tuner_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] worst_delay = W'(20);
  logic         start = 1'b0;
  logic         verdict_valid = 1'b0;
  logic         verdict_pass = 1'b0;
  logic         done;
  logic [W-1:0] trial_delay;
  logic         converged;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int exp_trial, exp_good;
  bit exp_conv;

  always #5 clk = ~clk;

  wait_tuner #(.DELAY_W(W)) uut (
    .clk(clk), .rst(rst), .worst_delay(worst_delay), .start(start),
    .verdict_valid(verdict_valid), .verdict_pass(verdict_pass),
    .done(done), .trial_delay(trial_delay), .converged(converged)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference search step, written from the requirements.
  function automatic void model_verdict(input bit pass);
    int gap;
    if (exp_conv) return;
    if (pass) begin
      exp_good = exp_trial;
      if (exp_trial == 1) exp_conv = 1;
      else exp_trial = exp_trial / 2;
    end else begin
      gap = (exp_good - exp_trial) / 2;
      if (gap == 0) begin
        exp_trial = exp_good;
        exp_conv = 1;
      end else exp_trial = exp_trial + gap;
    end
  endfunction

  task automatic do_reset(input int worst);
    @(negedge clk);
    rst = 1'b1;
    worst_delay = W'(worst);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_trial = (worst == 0) ? 1 : worst;
    exp_good = exp_trial;
    exp_conv = 0;
    check("R1 trial", int'(trial_delay), exp_trial);
    check("R1 converged", int'(converged), 0);
    check("R1 done", int'(done), 0);
  endtask

  // Start, count cycles to done, check width; optional stray start mid-count.
  task automatic timed_run(input bit poke);
    int n;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done) begin
      if (poke && n == 0) begin
        start = 1'b1;
        verdict_valid = 1'b1;
        verdict_pass = 1'b1;
      end else begin
        start = 1'b0;
        verdict_valid = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    verdict_valid = 1'b0;
    check("R2 countdown length", n, exp_trial);
    if (poke) check("R8 stray verdict ignored", int'(trial_delay), exp_trial);
    @(negedge clk);
    check("R2 done width", int'(done), 0);
  endtask

  task automatic give_verdict(input bit pass);
    verdict_valid = 1'b1;
    verdict_pass = pass;
    @(negedge clk);
    verdict_valid = 1'b0;
    model_verdict(pass);
    if (pass) check("R4 after pass", int'(trial_delay), exp_trial);
    else      check("R5 after fail", int'(trial_delay), exp_trial);
    check("R6 converged flag", int'(converged), int'(exp_conv));
  endtask

  initial begin
    void'($urandom(32'd1234));

    // Directed: clamp of zero worst case
    do_reset(0);

    // Directed: worst 20, threshold 7, with stray start mid-count
    do_reset(20);
    timed_run(1'b1);
    give_verdict(1'b1);                 // 20 -> 10
    check("R4 halve", int'(trial_delay), 10);
    // Start while awaiting verdict is ignored (R3)
    timed_run(1'b0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (15) @(negedge clk);
    check("R3 no second done", int'(done), 0);
    give_verdict(1'b1);                 // 10 -> 5
    repeat (14) @(negedge clk);
    check("R3 idle after ignored start", int'(done), 0);
    timed_run(1'b0);
    give_verdict(1'b0);                 // 5 + (10-5)/2 = 7
    check("R5 grow", int'(trial_delay), 7);
    timed_run(1'b0);
    give_verdict(1'b1);                 // good=7, trial 3
    timed_run(1'b0);
    give_verdict(1'b0);                 // 3+2 = 5
    timed_run(1'b0);
    give_verdict(1'b0);                 // 5+1 = 6
    timed_run(1'b0);
    give_verdict(1'b0);                 // gap 0 -> 7, converged
    check("R6 settles at good", int'(trial_delay), 7);
    check("R9 threshold 7", int'(trial_delay), 7);
    timed_run(1'b0);
    give_verdict(1'b1);
    check("R7 frozen after pass", int'(trial_delay), 7);
    check("R7 still converged", int'(converged), 1);

    // Directed: worst 1 passes at once
    do_reset(1);
    timed_run(1'b0);
    give_verdict(1'b1);
    check("R6 pass at one", int'(converged), 1);
    check("R6 stays one", int'(trial_delay), 1);

    // Directed: first attempt fails at worst
    do_reset(9);
    timed_run(1'b0);
    give_verdict(1'b0);
    check("R6 fail at worst", int'(trial_delay), 9);

    // Random threshold searches
    for (int t = 0; t < 12; t++) begin
      int worst, thr, k;
      worst = 1 + int'($urandom_range(254));
      thr = 1 + int'($urandom_range(worst - 1));
      do_reset(worst);
      k = 0;
      while (!exp_conv && k < 40) begin
        timed_run(($urandom_range(3) == 0) ? 1'b1 : 1'b0);
        give_verdict(exp_trial >= thr);
        k++;
      end
      check("R9 settles at threshold", int'(trial_delay), thr);
      timed_run(1'b0);
      give_verdict(1'b0);
      check("R7 fail ignored after converge", int'(trial_delay), thr);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule